// File: doc/BRIEF.md
# Wide-Read Narrow-Write Word Mover

This block is the data engine under a playback DMA controller. Once it has a word-aligned start address and a count of 32-bit words, it fetches the source in 64-bit beats on a memory-side read channel. It keeps the beats in a small buffer and hands them out one 32-bit word at a time on a peripheral-side write channel. The read side and the write side each keep their own address pointer. The read pointer walks in 8-byte steps and the write pointer in 4-byte steps.

Because the start address only has to be word aligned, the first beat may contain one word that must not be written, and the last beat may contain one word beyond the end of the transfer. The block drops both of these. A level-sensitive request from the peripheral paces the write side: the block offers a word only while that request is high. The block never accepts more beats than the buffer has room for. A one-cycle done strobe marks the acceptance of the final word.

Top module: `dw_word_mover`

## Requirements
- R1: The first read address is the start address with its low three bits cleared. Each later read address is the previous one plus 8, so bits [2:0] of every read address are zero.
- R2: The first write address is the start address. Each later write address is the previous one plus 4. Each written word equals the source word stored at that byte address. In a beat, bits [31:0] hold the word at the beat address and bits [63:32] hold the word at the beat address plus 4.
- R3: When bit 2 of the start address is 1, the first word written is bits [63:32] of the first beat, and bits [31:0] of that beat are never written.
- R4: A transfer of N words from start address A issues exactly (N + A[2] + 1) / 2 read requests, using integer division. Any unused half of the final beat is discarded.
- R5: `per_wr_valid` is high only in cycles where `per_req` is high. While `per_req` stays low, no word is written.
- R6: In-flight read requests plus buffered beats never exceed DEPTH. When the write side is held off, exactly DEPTH read requests are accepted and then reads stall.
- R7: `done` is high for exactly one cycle, the cycle in which the last word is accepted (`per_wr_valid` and `per_wr_ready` both high). `busy` is low in the following cycle.
- R8: A `start` pulse is ignored when `word_count` is 0 or when `busy` is high. An ignored pulse changes neither the addresses nor the number of words of the running transfer.
- R9: After reset, `busy`, `done`, `mem_rd_valid` and `per_wr_valid` are low. While `busy` is low, neither channel is driven valid.
- R10: While a write is offered and `per_wr_ready` is low, the offered address and data stay unchanged until the word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| start_addr | input | 32 | Word-aligned byte address of the first word |
| word_count | input | 16 | Number of 32-bit words, 1 to 0x8000 |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Strobe in the cycle the last word is accepted |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | 32 | Read request byte address, 8-byte aligned |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rsp_valid | input | 1 | Read data beat valid, returned in request order |
| mem_rsp_data | input | 64 | Read data beat |
| per_req | input | 1 | Peripheral wants data (level) |
| per_wr_valid | output | 1 | A word is offered to the peripheral |
| per_wr_addr | output | 32 | Byte address of the offered word |
| per_wr_data | output | 32 | Offered word |
| per_wr_ready | input | 1 | Peripheral accepts the offered word |

## Verification
The assertions assume that the memory returns exactly one beat for each accepted read request, in order, and never returns a beat that was not requested. They also assume that `start` comes with a `word_count` of at most 0x8000. The memory model in the bench records each accepted address in a queue. It answers from that queue with one beat per cycle, at least one cycle later, so it never returns an unrequested beat. The stimulus keeps every length within the legal range. The handshakes on both channels are throttled in several patterns, including a request that is held low long enough to fill the buffer.

// File: rtl/dwm_pkg.sv
package dwm_pkg;
    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 32;
    localparam int BEAT_W   = 64;
    localparam int CNT_W    = 16;
    localparam int WORD_LSB = $clog2(WORD_W / 8);
    localparam int BEAT_LSB = $clog2(BEAT_W / 8);
    localparam int HALF_BIT = BEAT_LSB - 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BEAT_W-1:0] beat_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CNT_W:0]    span_t;

    // Number of beats that cover `words` words starting at `start`.
    function automatic cnt_t beats_for(input addr_t start, input cnt_t words);
        span_t total;
        total = span_t'(words) + span_t'(start[HALF_BIT]) + span_t'(1);
        return cnt_t'(total >> 1);
    endfunction

    typedef struct packed {
        logic  active;
        addr_t ptr;
        cnt_t  left;
        logic  upper;
    } wr_state_t;
endpackage

// File: rtl/dwm_beat_buf.sv
module dwm_beat_buf
    import dwm_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  beat_t            push_beat,
    input  logic             pop,
    output beat_t            head,
    output logic [OCC_W-1:0] occ,
    output logic             nonempty
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [OCC_W-1:0] occ;
    } buf_state_t;

    buf_state_t s_d, s_q;
    beat_t      slot_q [DEPTH];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = step(s_q.wp);
        if (pop)  s_d.rp = step(s_q.rp);
        case ({push, pop})
            2'b10:   s_d.occ = s_q.occ + OCC_W'(1);
            2'b01:   s_d.occ = s_q.occ - OCC_W'(1);
            default: s_d.occ = s_q.occ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[s_q.wp] <= push_beat;
    end

    assign head     = slot_q[s_q.rp];
    assign occ      = s_q.occ;
    assign nonempty = (s_q.occ != '0);
endmodule

// File: rtl/dwm_rd_ctrl.sv
module dwm_rd_ctrl
    import dwm_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  addr_t            load_addr,
    input  cnt_t             load_words,
    input  logic [OCC_W-1:0] buf_occ,
    output logic             rd_valid,
    output addr_t            rd_addr,
    input  logic             rd_ready,
    input  logic             rsp_valid
);
    typedef struct packed {
        logic             active;
        addr_t            ptr;
        cnt_t             left;
        logic [OCC_W-1:0] pend;
    } rd_state_t;

    rd_state_t s_d, s_q;
    logic      room;
    logic      fire;

    always_comb begin
        s_d      = s_q;
        room     = ({1'b0, s_q.pend} + {1'b0, buf_occ}) < (OCC_W + 1)'(DEPTH);
        rd_valid = s_q.active && room;
        fire     = rd_valid && rd_ready;

        if (load) begin
            s_d.active = 1'b1;
            s_d.ptr    = load_addr & ~addr_t'(BEAT_W / 8 - 1);
            s_d.left   = beats_for(load_addr, load_words);
        end else if (fire) begin
            s_d.ptr  = s_q.ptr + addr_t'(BEAT_W / 8);
            s_d.left = s_q.left - cnt_t'(1);
            if (s_q.left == cnt_t'(1)) s_d.active = 1'b0;
        end

        case ({fire, rsp_valid})
            2'b10:   s_d.pend = s_q.pend + OCC_W'(1);
            2'b01:   s_d.pend = s_q.pend - OCC_W'(1);
            default: s_d.pend = s_q.pend;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_addr = s_q.ptr;
endmodule

// File: rtl/dwm_wr_ctrl.sv
module dwm_wr_ctrl
    import dwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  addr_t load_addr,
    input  cnt_t  load_words,
    input  logic  per_req,
    input  logic  wr_ready,
    input  logic  buf_nonempty,
    input  beat_t head,
    output logic  wr_valid,
    output addr_t wr_addr,
    output word_t wr_data,
    output logic  pop,
    output logic  done,
    output logic  busy
);
    wr_state_t s_d, s_q;
    logic      fire;
    logic      last;

    always_comb begin
        s_d      = s_q;
        wr_valid = s_q.active && per_req && buf_nonempty;
        fire     = wr_valid && wr_ready;
        last     = (s_q.left == cnt_t'(1));
        wr_data  = s_q.upper ? head[BEAT_W-1:WORD_W] : head[WORD_W-1:0];
        pop      = fire && (s_q.upper || last);
        done     = fire && last;

        if (load) begin
            s_d.active = 1'b1;
            s_d.ptr    = load_addr & ~addr_t'(WORD_W / 8 - 1);
            s_d.left   = load_words;
            s_d.upper  = load_addr[HALF_BIT];
        end else if (fire) begin
            s_d.ptr   = s_q.ptr + addr_t'(WORD_W / 8);
            s_d.left  = s_q.left - cnt_t'(1);
            s_d.upper = ~s_q.upper;
            if (last) s_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_addr = s_q.ptr;
    assign busy    = s_q.active;
endmodule

// File: rtl/dw_word_mover.sv
module dw_word_mover
    import dwm_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_count,
    output logic              busy,
    output logic              done,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic              mem_rsp_valid,
    input  logic [BEAT_W-1:0] mem_rsp_data,
    input  logic              per_req,
    output logic              per_wr_valid,
    output logic [ADDR_W-1:0] per_wr_addr,
    output logic [WORD_W-1:0] per_wr_data,
    input  logic              per_wr_ready
);
    logic             load;
    logic [OCC_W-1:0] buf_occ;
    logic             buf_nonempty;
    beat_t            buf_head;
    logic             buf_pop;

    assign load = start && !busy && (word_count != '0);

    dwm_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_addr  (start_addr),
        .load_words (word_count),
        .buf_occ    (buf_occ),
        .rd_valid   (mem_rd_valid),
        .rd_addr    (mem_rd_addr),
        .rd_ready   (mem_rd_ready),
        .rsp_valid  (mem_rsp_valid)
    );

    dwm_beat_buf #(.DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (mem_rsp_valid),
        .push_beat (mem_rsp_data),
        .pop       (buf_pop),
        .head      (buf_head),
        .occ       (buf_occ),
        .nonempty  (buf_nonempty)
    );

    dwm_wr_ctrl u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .load_addr    (start_addr),
        .load_words   (word_count),
        .per_req      (per_req),
        .wr_ready     (per_wr_ready),
        .buf_nonempty (buf_nonempty),
        .head         (buf_head),
        .wr_valid     (per_wr_valid),
        .wr_addr      (per_wr_addr),
        .wr_data      (per_wr_data),
        .pop          (buf_pop),
        .done         (done),
        .busy         (busy)
    );
endmodule

// File: rtl/dwm_checker.sv
module dwm_checker
    import dwm_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic             rd_ready,
    input addr_t            rd_addr,
    input logic             rsp_valid,
    input logic             per_req,
    input logic             wr_valid,
    input logic             wr_ready,
    input addr_t            wr_addr,
    input logic             done,
    input logic             busy,
    input logic [OCC_W-1:0] buf_occ
);
    logic [7:0] pend_q;
    addr_t      rd_last_q;
    addr_t      wr_last_q;
    logic       rd_seen_q;
    logic       wr_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= '0;
            rd_last_q <= '0;
            wr_last_q <= '0;
            rd_seen_q <= 1'b0;
            wr_seen_q <= 1'b0;
        end else begin
            pend_q <= pend_q + 8'(rd_valid && rd_ready) - 8'(rsp_valid);
            if (!busy) begin
                rd_seen_q <= 1'b0;
                wr_seen_q <= 1'b0;
            end else begin
                if (rd_valid && rd_ready) begin
                    rd_seen_q <= 1'b1;
                    rd_last_q <= rd_addr;
                end
                if (wr_valid && wr_ready) begin
                    wr_seen_q <= 1'b1;
                    wr_last_q <= wr_addr;
                end
            end
        end
    end

    AST_RD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_addr[BEAT_LSB-1:0] == '0));  // R1
    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_seen_q) |-> (rd_addr == rd_last_q + addr_t'(BEAT_W / 8)));  // R1
    AST_WR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[WORD_LSB-1:0] == '0));  // R2
    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_seen_q) |-> (wr_addr == wr_last_q + addr_t'(WORD_W / 8)));  // R2
    AST_WR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> per_req);  // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (9'(pend_q) + 9'(buf_occ)) <= 9'(DEPTH));  // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R7
    AST_DONE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_valid && wr_ready));  // R7
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);  // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_valid && !rd_valid));  // R9
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) ##1 wr_valid |-> $stable(wr_addr));  // R10
endmodule

bind dw_word_mover dwm_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (mem_rd_valid),
    .rd_ready  (mem_rd_ready),
    .rd_addr   (mem_rd_addr),
    .rsp_valid (mem_rsp_valid),
    .per_req   (per_req),
    .wr_valid  (per_wr_valid),
    .wr_ready  (per_wr_ready),
    .wr_addr   (per_wr_addr),
    .done      (done),
    .busy      (busy),
    .buf_occ   (buf_occ)
);

// File: tb/dw_word_mover_tb.sv
module dw_word_mover_tb;
    import dwm_pkg::*;

    localparam int DEPTH = 4;
    localparam int NVEC  = 9;
    // {start address, word count, request pattern, ready pattern}
    localparam logic [51:0] VEC [NVEC] = '{
        {32'h0000_1000, 16'd8,     2'd0, 2'd0},
        {32'h0000_2004, 16'd5,     2'd0, 2'd0},
        {32'h0000_3004, 16'd4,     2'd1, 2'd0},
        {32'h0000_4000, 16'd1,     2'd0, 2'd1},
        {32'h0000_5004, 16'd1,     2'd2, 2'd2},
        {32'h0000_6000, 16'd7,     2'd1, 2'd1},
        {32'h0000_7FF8, 16'd3,     2'd0, 2'd0},
        {32'h0000_8004, 16'd40,    2'd2, 2'd1},
        {32'h0001_0004, 16'h8000,  2'd0, 2'd0}
    };

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    logic  start = 1'b0;
    addr_t start_addr = '0;
    cnt_t  word_count = '0;
    logic  busy, done;
    logic  rd_valid;
    addr_t rd_addr;
    logic  rd_ready = 1'b0;
    logic  rsp_valid = 1'b0;
    beat_t rsp_data = '0;
    logic  per_req = 1'b0;
    logic  wr_valid;
    addr_t wr_addr;
    word_t wr_data;
    logic  wr_ready = 1'b0;

    always #5 clk = ~clk;

    dw_word_mover #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .word_count(word_count), .busy(busy), .done(done),
        .mem_rd_valid(rd_valid), .mem_rd_addr(rd_addr), .mem_rd_ready(rd_ready),
        .mem_rsp_valid(rsp_valid), .mem_rsp_data(rsp_data),
        .per_req(per_req), .per_wr_valid(wr_valid), .per_wr_addr(wr_addr),
        .per_wr_data(wr_data), .per_wr_ready(wr_ready)
    );

    function automatic word_t wval(input addr_t a);
        return a ^ 32'hC3C3_5A5A;
    endfunction

    function automatic logic pat(input int mode, input int c);
        case (mode)
            0:       return 1'b1;
            1:       return (c % 2) == 0;
            2:       return (c % 3) == 0;
            default: return 1'b0;
        endcase
    endfunction

    int checks = 0, errors = 0, m_checks = 0, m_errors = 0;
    int pmode = 3, rmode = 0;
    int cyc = 0;
    int wr_words = 0, rd_beats = 0, done_cnt = 0, bad_req = 0;
    addr_t rq [128];
    int rq_h = 0, rq_t = 0;
    addr_t exp_wr = '0, exp_rd = '0;
    logic  done_prev = 1'b0, prev_stall = 1'b0;
    addr_t prev_wa = '0;
    word_t prev_wd = '0;

    task automatic mchk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        m_checks++;
        if (!ok) begin
            m_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model, peripheral model and port monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            per_req  = pat(pmode, cyc);
            wr_ready = pat(rmode, cyc);
            rd_ready = (rmode == 0) || (cyc % 2 == 1);
            if (rq_h != rq_t) begin
                rsp_valid = 1'b1;
                rsp_data  = {wval(rq[rq_h] + 32'd4), wval(rq[rq_h])};
                rq_h      = (rq_h + 1) % 128;
            end else begin
                rsp_valid = 1'b0;
                rsp_data  = '0;
            end
        end
        #1;
        if (rst_n) begin
            if (done_prev) mchk(busy == 1'b0, "R7 busy after done", 64'(busy), 64'd0);
            done_prev = done;
            if (start && !busy && word_count != '0) begin
                exp_wr = start_addr;
                exp_rd = start_addr & ~addr_t'(7);
            end
            if (rd_valid && rd_ready) begin
                mchk(rd_addr == exp_rd, "R1 read address", 64'(rd_addr), 64'(exp_rd));
                exp_rd   = exp_rd + 32'd8;
                rq[rq_t] = rd_addr;
                rq_t     = (rq_t + 1) % 128;
                rd_beats++;
            end
            if (wr_valid && !per_req) bad_req++;
            if (prev_stall && wr_valid)
                mchk(wr_addr == prev_wa && wr_data == prev_wd, "R10 held offer",
                     {wr_addr, wr_data}, {prev_wa, prev_wd});
            prev_stall = wr_valid && !wr_ready;
            prev_wa    = wr_addr;
            prev_wd    = wr_data;
            if (wr_valid && wr_ready) begin
                mchk(wr_addr == exp_wr && wr_data == wval(exp_wr),
                     exp_wr[2] ? "R3 word" : "R2 word",
                     {wr_addr, wr_data}, {exp_wr, wval(exp_wr)});
                exp_wr = exp_wr + 32'd4;
                wr_words++;
            end
            if (done) done_cnt++;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors + m_errors + 1, checks + m_checks + 1);
        $finish;
    end

    task automatic run(input addr_t a, input cnt_t n, input int pm, input int rm);
        int bw, br, bd, bb, t, beats;
        bw = wr_words; br = rd_beats; bd = done_cnt; bb = bad_req;
        beats = (int'(n) + int'(a[2]) + 1) / 2;
        pmode = pm; rmode = rm;
        @(negedge clk);
        start = 1'b1; start_addr = a; word_count = n;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (done_cnt == bd && t < 80000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        chk(done_cnt - bd == 1, "R7 single done", 64'(done_cnt - bd), 64'd1);
        chk(wr_words - bw == int'(n), "R2 words written", 64'(wr_words - bw), 64'(n));
        chk(rd_beats - br == beats, "R4 read beats", 64'(rd_beats - br), 64'(beats));
        chk(bad_req == bb, "R5 write without request", 64'(bad_req - bb), 64'd0);
        chk(busy == 1'b0, "R7 idle after run", 64'(busy), 64'd0);
    endtask

    initial begin
        int bw, br, bd, t;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !rd_valid && !wr_valid, "R9 reset state",
            {busy, done, rd_valid, wr_valid}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !rd_valid && !wr_valid, "R9 idle after reset",
            {busy, rd_valid, wr_valid}, 64'd0);

        // length zero is ignored
        br = rd_beats;
        @(negedge clk);
        start = 1'b1; start_addr = 32'h0000_0100; word_count = '0;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R8 zero length busy", 64'(busy), 64'd0);
        chk(rd_beats == br, "R8 zero length reads", 64'(rd_beats - br), 64'd0);

        for (int i = 0; i < NVEC; i++)
            run(VEC[i][51:20], VEC[i][19:4], int'(VEC[i][3:2]), int'(VEC[i][1:0]));

        // request held low: buffer fills, reads stall, start while busy ignored
        bw = wr_words; br = rd_beats; bd = done_cnt;
        pmode = 3; rmode = 0;
        @(negedge clk);
        start = 1'b1; start_addr = 32'h0002_0000; word_count = 16'd20;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk(rd_beats - br == DEPTH, "R6 reads stall at depth", 64'(rd_beats - br), 64'(DEPTH));
        chk(wr_words == bw, "R5 nothing written while low", 64'(wr_words - bw), 64'd0);
        chk(busy == 1'b1, "R6 still busy", 64'(busy), 64'd1);
        start = 1'b1; start_addr = 32'h0003_0004; word_count = 16'd2;
        @(negedge clk);
        start = 1'b0;
        pmode = 0;
        t = 0;
        while (done_cnt == bd && t < 2000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        chk(wr_words - bw == 20, "R8 busy start ignored words", 64'(wr_words - bw), 64'd20);
        chk(rd_beats - br == 10, "R8 busy start ignored reads", 64'(rd_beats - br), 64'd10);
        chk(done_cnt - bd == 1, "R7 done after stall", 64'(done_cnt - bd), 64'd1);

        $display("  Result: errors=%0d of %0d checks", errors + m_errors, checks + m_checks);
        $finish;
    end
endmodule